// File: doc/BRIEF.md
# Fence-Aware Store Buffer

This block sits between a core's retirement stage and the data cache write port. Stores arrive in program order and wait in a small circular queue until the cache accepts them. Plain stores leave strictly in order. Non-temporal (streaming) stores may leave early, and can overtake one another, but only within a run that no plain store or store-fence marker interrupts. Inside such a run, the buffer offers the lowest address first.

A store fence does not drain the queue. It enters as a marker entry, so retiring it never waits. The marker keeps younger non-temporal stores from committing until it has left the queue. A full fence takes no slot. Instead it lowers the load-permission output until every older entry has gone, which is the only way a younger load is kept from passing an older store. A load fence has no input here because it does not change the buffer.

The queue depth must be a power of two.

Top module: `fence_store_buffer`

## Requirements
- R1: After reset, `empty` is 1, `load_ok` is 1, `wr_valid` is 0 and `st_ready` is 1.
- R2: `st_kind` encodes 0 = plain store, 1 = non-temporal store, 2 = store fence, 3 = full fence. An item is taken on a cycle where `st_valid` and `st_ready` are both high. `st_ready` is low while all DEPTH slots are occupied, and also while a full fence is pending.
- R3: Plain stores reach the write port in program order. No younger entry of any kind commits before an older plain store.
- R4: A non-temporal store never commits while an older store-fence marker is still in the queue.
- R5: When the oldest entry is a non-temporal store, the buffer offers the entry with the lowest address among the consecutive non-temporal entries that start there. On equal addresses it offers the older entry.
- R6: A store-fence marker that becomes the oldest entry leaves the queue at the next clock edge and drives no cache write. A store fence is accepted while older stores are still queued.
- R7: A full fence that is taken consumes no slot. It drives `load_ok` low from the next cycle, and `load_ok` stays low until the edge after `empty` has been seen high.
- R8: While no full fence is pending, `load_ok` stays high, even when stores are buffered behind a store fence.
- R9: While `wr_valid` is high and `wr_ready` is low, the offered address and data stay unchanged on the next cycle.
- R10: `empty` is high exactly when the queue holds no uncommitted store or marker. `wr_valid` is never high while `empty` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Retire item valid |
| st_ready | output | 1 | Buffer can take a retire item |
| st_kind | input | 2 | Item kind (see R2) |
| st_addr | input | AW | Store address |
| st_data | input | DW | Store data |
| wr_valid | output | 1 | Cache write offered |
| wr_ready | input | 1 | Cache takes the offered write |
| wr_addr | output | AW | Cache write address |
| wr_data | output | DW | Cache write data |
| load_ok | output | 1 | Younger loads may execute |
| empty | output | 1 | No entry left in the buffer |

## Verification
The bench sweeps every sequence of five items over the four kinds, so each ordering of plain stores, streaming stores, markers and full fences is covered. It applies three cache back-pressure patterns. One of them locks an offer and then adds lower-address streaming stores behind it.

A design that let a streaming store slip past a marker, or past an older plain store, would show the wrong address at the write port. A design that drained on a store fence would show a missing or late offer. A design that dropped the offer lock would swap the offered entry while `wr_ready` is low. A full-fence flag that cleared early, or never cleared, shows up as a `load_ok` mismatch.

A fill phase holds the cache back so that the full condition refuses a retire item.

// File: rtl/fence_store_buffer.sv
module fence_store_buffer #(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          st_valid,
  output logic          st_ready,
  input  logic [1:0]    st_kind,
  input  logic [AW-1:0] st_addr,
  input  logic [DW-1:0] st_data,
  output logic          wr_valid,
  input  logic          wr_ready,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          load_ok,
  output logic          empty
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;
  localparam logic [1:0] K_PLAIN = 2'd0, K_NT = 2'd1, K_SF = 2'd2, K_FULL = 2'd3;

  logic [DEPTH-1:0] vld;
  logic [1:0]       knd [DEPTH];
  logic [AW-1:0]    adr [DEPTH];
  logic [DW-1:0]    dat [DEPTH];

  logic [PW-1:0] head, tail, lock_idx;
  logic [CW-1:0] cnt;
  logic          fpend, lock;

  logic          found, have, stop;
  logic [PW-1:0] oldest, best, sel, p;

  always_comb begin
    found  = 1'b0;
    oldest = head;
    have   = 1'b0;
    best   = head;
    stop   = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      p = head + PW'(i);
      if (!found && vld[p]) begin
        found  = 1'b1;
        oldest = p;
      end
      if (!stop && vld[p]) begin
        if (knd[p] != K_NT) stop = 1'b1;
        else if (!have || adr[p] < adr[best]) begin
          have = 1'b1;
          best = p;
        end
      end
    end
  end

  assign sel      = lock ? lock_idx : (have ? best : oldest);
  assign wr_valid = lock | (found && knd[oldest] != K_SF);
  assign wr_addr  = adr[sel];
  assign wr_data  = dat[sel];

  logic take, mk_ret, acc, enq, head_adv;
  assign take     = wr_valid && wr_ready;
  assign mk_ret   = !lock && found && knd[oldest] == K_SF;
  assign st_ready = (cnt != CW'(DEPTH)) && !fpend;
  assign acc      = st_valid && st_ready;
  assign enq      = acc && st_kind != K_FULL;
  assign head_adv = (cnt != '0) &&
                    (!vld[head] || (take && sel == head) || (mk_ret && oldest == head));
  assign empty    = ~|vld;
  assign load_ok  = !fpend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld      <= '0;
      head     <= '0;
      tail     <= '0;
      cnt      <= '0;
      fpend    <= 1'b0;
      lock     <= 1'b0;
      lock_idx <= '0;
    end else begin
      if (enq) begin
        vld[tail] <= 1'b1;
        tail      <= tail + 1'b1;
      end
      if (take)   vld[sel]    <= 1'b0;
      if (mk_ret) vld[oldest] <= 1'b0;
      if (head_adv) head <= head + 1'b1;
      cnt <= cnt + CW'(enq) - CW'(head_adv);
      if (acc && st_kind == K_FULL) fpend <= 1'b1;
      else if (fpend && empty)      fpend <= 1'b0;
      lock     <= wr_valid && !wr_ready;
      lock_idx <= sel;
    end
  end

  always_ff @(posedge clk) begin
    if (enq) begin
      knd[tail] <= st_kind;
      adr[tail] <= st_addr;
      dat[tail] <= st_data;
    end
  end
endmodule

// File: rtl/fence_store_buffer_chk.sv
module fence_store_buffer_chk #(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int DEPTH = 8,
  parameter int CW    = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          st_valid,
  input logic          st_ready,
  input logic [1:0]    st_kind,
  input logic          wr_valid,
  input logic          wr_ready,
  input logic [AW-1:0] wr_addr,
  input logic [DW-1:0] wr_data,
  input logic          load_ok,
  input logic          empty,
  input logic [CW-1:0] cnt
);
  assert_no_accept_when_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CW'(DEPTH)) |-> !st_ready);

  assert_no_retire_while_fenced_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !load_ok |-> !st_ready);

  assert_offer_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

  assert_fence_blocks_loads_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && st_ready && st_kind == 2'd3) |=> !load_ok);

  assert_fence_waits_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_ok && !empty) |=> !load_ok);

  assert_loads_free_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (load_ok && !(st_valid && st_ready && st_kind == 2'd3)) |=> load_ok);

  assert_empty_no_offer_R10: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !wr_valid);
endmodule

bind fence_store_buffer fence_store_buffer_chk #(
  .AW(AW), .DW(DW), .DEPTH(DEPTH), .CW(CW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready),
  .st_kind(st_kind), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .wr_addr(wr_addr), .wr_data(wr_data), .load_ok(load_ok),
  .empty(empty), .cnt(cnt)
);

// File: tb/sim_fence_store_buffer.sv
module sim_fence_store_buffer;
  localparam int AW = 16, DW = 32, DEPTH = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          st_valid = 1'b0, st_ready;
  logic [1:0]    st_kind = '0;
  logic [AW-1:0] st_addr = '0;
  logic [DW-1:0] st_data = '0;
  logic          wr_valid, wr_ready = 1'b0;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;
  logic          load_ok, empty;

  always #5 clk = ~clk;

  fence_store_buffer #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready),
    .st_kind(st_kind), .st_addr(st_addr), .st_data(st_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
    .wr_data(wr_data), .load_ok(load_ok), .empty(empty)
  );

  typedef struct { int id; int k; int a; int d; } item_t;
  item_t stim[$];
  item_t model[$];

  int checks = 0, fails = 0, cyc = 0, next_id = 0;
  int locked_id = -1, rmode = 0, hold_until = 0;
  bit mfp = 1'b0, started = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
    end
  endtask

  function automatic int pick();
    int best;
    if (locked_id >= 0) begin
      for (int i = 0; i < model.size(); i++) if (model[i].id == locked_id) return i;
      return -2;
    end
    if (model.size() == 0) return -1;
    if (model[0].k == 2) return -1;
    if (model[0].k == 0) return 0;
    best = 0;
    for (int i = 1; i < model.size(); i++) begin
      if (model[i].k != 1) break;
      if (model[i].a < model[best].a) best = i;
    end
    return best;
  endfunction

  function automatic bit ready_fn(input int c);
    case (rmode)
      0: return 1'b1;
      1: return c[0];
      2: return (c % 4) == 3;
      default: return c >= hold_until;
    endcase
  endfunction

  always @(negedge clk) begin
    if (started) begin
      int e;
      bit clr;
      string tag;
      cyc++;
      if (cyc > 180000) begin
        fails++;
        $display("FAIL watchdog: actual %0d cycles expected at most 180000", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
      end
      e = pick();
      if (model.size() == 0) tag = "R10";
      else if (model[0].k == 2 && locked_id < 0) tag = "R6";
      else if (model[0].k == 0) tag = "R3";
      else tag = "R4/R5";
      chk(wr_valid == (e >= 0), tag, int'(wr_valid), int'(e >= 0));
      if (wr_valid && e >= 0) begin
        chk(int'(wr_addr) == model[e].a, locked_id >= 0 ? "R9" : tag, int'(wr_addr), model[e].a);
        chk(int'(wr_data) == model[e].d, locked_id >= 0 ? "R9" : tag, int'(wr_data), model[e].d);
      end
      chk(empty == (model.size() == 0), "R10", int'(empty), int'(model.size() == 0));
      chk(load_ok == !mfp, "R7/R8", int'(load_ok), int'(!mfp));
      if (mfp || model.size() >= DEPTH) chk(!st_ready, "R2", int'(st_ready), 0);
      clr = mfp && model.size() == 0;

      wr_ready = ready_fn(cyc);
      st_valid = stim.size() > 0;
      if (st_valid) begin
        st_kind = 2'(stim[0].k);
        st_addr = AW'(stim[0].a);
        st_data = DW'(stim[0].d);
      end

      if (wr_valid && e >= 0) begin
        if (wr_ready) begin
          model.delete(e);
          locked_id = -1;
        end else locked_id = model[e].id;
      end else if (!wr_valid && model.size() > 0 && model[0].k == 2) begin
        model.pop_front();
      end
      if (clr) mfp = 1'b0;
      if (st_valid && st_ready) begin
        if (stim[0].k == 3) mfp = 1'b1;
        else model.push_back(stim[0]);
        void'(stim.pop_front());
      end
    end
  end

  task automatic add(input int k, input int a);
    item_t t;
    t.id = next_id; t.k = k; t.a = a; t.d = 32'h5000 + next_id;
    next_id++;
    stim.push_back(t);
  endtask

  task automatic drain();
    while (stim.size() != 0 || model.size() != 0 || mfp) @(posedge clk);
    repeat (DEPTH + 2) @(posedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(empty == 1'b1, "R1", int'(empty), 1);
    chk(load_ok == 1'b1, "R1", int'(load_ok), 1);
    chk(wr_valid == 1'b0, "R1", int'(wr_valid), 0);
    chk(st_ready == 1'b1, "R1", int'(st_ready), 1);
    started = 1'b1;

    // R2: fill with plain stores while the cache refuses, so the full condition stalls retire
    rmode = 3;
    hold_until = cyc + 30;
    for (int i = 0; i < 10; i++) add(0, 15 - i);
    drain();

    // R3 R4 R5 R6 R7 R8 R9: every 5-item kind sequence under three back-pressure patterns
    for (int s = 0; s < 1024; s++) begin
      rmode = s % 3;
      for (int i = 0; i < 5; i++) add((s >> (2 * i)) & 3, (s * 5 + i * 11) & 15);
      drain();
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule